// File: doc/BRIEF.md
# Mode-Dependent Video RAM Address Mapper

This block generates addresses for the data port of a video processor. Software first loads a 14-bit address counter with a write command. It then issues data-port accesses, and the counter advances by a programmable step after each one. Every accepted access leaves the block as a beat on a valid/ready stream. A beat carries the physical 16-bit video RAM byte address, a byte-swap flag and the write word, already put in the final byte order.

There are two address mappings. In native mode the counter drives the low 14 physical bits unchanged. The top two bits come from a page latched with the command, but only when the expanded-memory control is on. Legacy mode serves an older display format and works differently:

- Counter bit 0 no longer addresses memory. Instead it requests a byte swap of the write word.
- The remaining counter bits are permuted onto the physical address.
- The two top physical bits are always zero, so legacy accesses stay in the first 16 KiB.
- The step applies to the word offset held in counter bits 13..1.
- The step register can only be changed while native mode is selected.

The access stream has one output register. An access is taken only when that register is empty or is being emptied in the same cycle. An access is also never taken in a cycle where a command loads the counter. While `mem_valid` is high and `mem_ready` is low, every beat field stays frozen.

Top module: `vram_addr_mapper`

## Requirements
- R1: After reset, `mem_valid` is 0, `acc_ready` is 1, the counter is 0 and the step is 0, so the first access without a command is issued at physical address 0x0000.
- R2: In native mode (`legacy_mode`=0) a beat has `mem_addr[13:0]` equal to the counter and `mem_swap`=0, and `mem_wdata` equals `acc_wdata`. `mem_addr[15:14]` is the page (bits 15:14 of the last `cmd_addr`) when `xmem_en`=1, and 0 otherwise.
- R3: In legacy mode physical bit 0 is 0 and physical bit 1 is counter bit 9. Physical bits 2..9 are counter bits 1..8, and physical bits 10..13 are counter bits 10..13.
- R4: In legacy mode `mem_addr[15:14]` is 0 whatever the values of `xmem_en` and the page.
- R5: In legacy mode with counter bit 0 set, `mem_swap`=1 and `mem_wdata` holds `acc_wdata` with its two bytes exchanged. With counter bit 0 clear, `mem_swap`=0 and the data passes through unchanged.
- R6: In native mode each accepted access adds the step to the 14-bit counter modulo 16384. For example, a step of 2 from 0x3FFE gives 0x0000.
- R7: In legacy mode each accepted access adds twice the step to the counter modulo 16384. A step of 1 therefore advances the word offset by one, and the counter wraps from 0x3FFE to 0x0000.
- R8: Asserting `inc_we` while `legacy_mode`=1 leaves the step unchanged. Asserting it in native mode sets the step to `inc_val` from the next cycle.
- R9: `cmd_load` sets the counter to `cmd_addr[13:0]` and the page to `cmd_addr[15:14]`, and it forces `acc_ready` low in that cycle.
- R10: `acc_ready` equals (`!mem_valid || mem_ready`) and `!cmd_load`. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_swap` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | 1 selects the legacy mapping, 0 the native mapping |
| xmem_en | input | 1 | Expanded-memory control; lets the page drive the top bits in native mode |
| cmd_load | input | 1 | Load the counter and page from `cmd_addr` |
| cmd_addr | input | 16 | Command address: bits 13:0 counter, bits 15:14 page |
| inc_we | input | 1 | Write the step register (native mode only) |
| inc_val | input | 8 | New step value |
| acc_valid | input | 1 | Data-port access request |
| acc_ready | output | 1 | Access accepted when high together with `acc_valid` |
| acc_wdata | input | 16 | Write word of the access |
| mem_valid | output | 1 | Beat towards video RAM is valid |
| mem_ready | input | 1 | Video RAM side takes the beat |
| mem_addr | output | 16 | Physical byte address |
| mem_swap | output | 1 | Byte swap was applied to `mem_wdata` |
| mem_wdata | output | 16 | Write word in final byte order |

## Verification
The bench uses the default parameters: a 14-bit counter, a 16-bit physical address, 16-bit data, an 8-bit step, and counter bit 9 as the bit that moves down to physical bit 1. With these values a few hundred cycles are enough to reach both wrap points. The bench also reaches each of the permuted bit positions and the page bits, and it holds the output back under random `mem_ready`. Random steps are kept small, so accesses often land near the 0x3FFE boundary in both modes after directed loads there.

// File: rtl/vam_pkg.sv
package vam_pkg;
  typedef enum logic {
    MAP_NATIVE = 1'b0,
    MAP_LEGACY = 1'b1
  } map_mode_e;

  localparam int unsigned DEF_CNT_W  = 14;
  localparam int unsigned DEF_PHYS_W = 16;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_STEP_W = 8;
  localparam int unsigned DEF_JUMP   = 9;
endpackage

// File: rtl/vam_addr_counter.sv
// Address counter with programmable step; the step register is locked in legacy mode.
module vam_addr_counter
  import vam_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned PAGE_W = 2,
  parameter int unsigned STEP_W = DEF_STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  map_mode_e         mode,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [PAGE_W-1:0] load_page,
  input  logic              step_we,
  input  logic [STEP_W-1:0] step_val,
  input  logic              advance,
  output logic [CNT_W-1:0]  cnt,
  output logic [PAGE_W-1:0] page
);
  localparam int unsigned ADD_W = STEP_W + 1;

  logic [STEP_W-1:0] step_q;
  logic [ADD_W-1:0]  add_amt;
  logic [CNT_W-1:0]  add_ext;
  logic [CNT_W-1:0]  cnt_next;

  // Legacy mode steps the word offset held in the upper counter bits.
  always_comb begin
    if (mode == MAP_LEGACY) add_amt = {step_q, 1'b0};
    else                    add_amt = {1'b0, step_q};
    add_ext  = CNT_W'(add_amt);
    cnt_next = cnt + add_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      page <= '0;
    end else if (load) begin
      cnt  <= load_cnt;
      page <= load_page;
    end else if (advance) begin
      cnt  <= cnt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               step_q <= '0;
    else if (step_we && mode == MAP_NATIVE)   step_q <= step_val;
  end
endmodule

// File: rtl/vam_addr_permute.sv
// Combinational mapping of counter bits onto the physical byte address.
module vam_addr_permute
  import vam_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned PHYS_W   = DEF_PHYS_W,
  parameter int unsigned JUMP_BIT = DEF_JUMP
) (
  input  map_mode_e                 mode,
  input  logic                      xmem_en,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [PHYS_W-CNT_W-1:0]   page,
  output logic [PHYS_W-1:0]         phys,
  output logic                      swap
);
  localparam int unsigned PAGE_W = PHYS_W - CNT_W;

  logic [CNT_W-1:0]  legacy_low;
  logic [PAGE_W-1:0] native_high;

  // Legacy order: bit 0 dropped, JUMP_BIT moves to bit 1, 1..JUMP_BIT-1 move up one.
  for (genvar k = 0; k < CNT_W; k++) begin : g_perm
    if (k == 0) begin : g_zero
      assign legacy_low[k] = 1'b0;
    end else if (k == 1) begin : g_jump
      assign legacy_low[k] = cnt[JUMP_BIT];
    end else if (k <= JUMP_BIT) begin : g_shift
      assign legacy_low[k] = cnt[k-1];
    end else begin : g_keep
      assign legacy_low[k] = cnt[k];
    end
  end

  assign native_high = xmem_en ? page : '0;

  always_comb begin
    if (mode == MAP_LEGACY) begin
      phys = {{PAGE_W{1'b0}}, legacy_low};
      swap = cnt[0];
    end else begin
      phys = {native_high, cnt};
      swap = 1'b0;
    end
  end
endmodule

// File: rtl/vam_out_stage.sv
// Single output register on the memory-side stream, with optional byte reversal.
module vam_out_stage #(
  parameter int unsigned PHYS_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic [PHYS_W-1:0] in_addr,
  input  logic              in_swap,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              can_take,
  output logic [PHYS_W-1:0] out_addr,
  output logic              out_swap,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] reversed;
  logic [DATA_W-1:0] data_sel;

  for (genvar b = 0; b < NBYTES; b++) begin : g_rev
    assign reversed[b*8 +: 8] = in_data[(NBYTES-1-b)*8 +: 8];
  end

  assign data_sel = in_swap ? reversed : in_data;
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_swap  <= 1'b0;
      out_data  <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
      out_swap  <= in_swap;
      out_data  <= data_sel;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vram_addr_mapper.sv
module vram_addr_mapper
  import vam_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned PHYS_W   = DEF_PHYS_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned STEP_W   = DEF_STEP_W,
  parameter int unsigned JUMP_BIT = DEF_JUMP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_mode,
  input  logic              xmem_en,
  input  logic              cmd_load,
  input  logic [PHYS_W-1:0] cmd_addr,
  input  logic              inc_we,
  input  logic [STEP_W-1:0] inc_val,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              mem_swap,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int unsigned PAGE_W = PHYS_W - CNT_W;

  map_mode_e         mode;
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] page;
  logic [PHYS_W-1:0] phys;
  logic              swap;
  logic              can_take;
  logic              fire;

  assign mode      = legacy_mode ? MAP_LEGACY : MAP_NATIVE;
  assign acc_ready = can_take && !cmd_load;
  assign fire      = acc_valid && acc_ready;

  vam_addr_counter #(
    .CNT_W (CNT_W),
    .PAGE_W(PAGE_W),
    .STEP_W(STEP_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .load     (cmd_load),
    .load_cnt (cmd_addr[CNT_W-1:0]),
    .load_page(cmd_addr[PHYS_W-1:CNT_W]),
    .step_we  (inc_we),
    .step_val (inc_val),
    .advance  (fire),
    .cnt      (cnt),
    .page     (page)
  );

  vam_addr_permute #(
    .CNT_W   (CNT_W),
    .PHYS_W  (PHYS_W),
    .JUMP_BIT(JUMP_BIT)
  ) u_perm (
    .mode   (mode),
    .xmem_en(xmem_en),
    .cnt    (cnt),
    .page   (page),
    .phys   (phys),
    .swap   (swap)
  );

  vam_out_stage #(
    .PHYS_W(PHYS_W),
    .DATA_W(DATA_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (fire),
    .in_addr  (phys),
    .in_swap  (swap),
    .in_data  (acc_wdata),
    .out_valid(mem_valid),
    .out_ready(mem_ready),
    .can_take (can_take),
    .out_addr (mem_addr),
    .out_swap (mem_swap),
    .out_data (mem_wdata)
  );
endmodule

// File: rtl/vam_checker.sv
module vam_checker #(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned PHYS_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              legacy_mode,
  input logic              cmd_load,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [PHYS_W-1:0] mem_addr,
  input logic              mem_swap,
  input logic [DATA_W-1:0] mem_wdata
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_swap) && $stable(mem_wdata)));

  // R10
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !acc_ready);

  // R9
  load_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |-> !acc_ready);

  // R4
  legacy_low16k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && legacy_mode) |=> (mem_addr[PHYS_W-1:CNT_W] == '0));

  // R3
  legacy_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && legacy_mode) |=> (mem_addr[0] == 1'b0));

  // R2
  native_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !legacy_mode) |=> (!mem_swap && mem_wdata == $past(acc_wdata)));
endmodule

bind vram_addr_mapper vam_checker #(
  .CNT_W (CNT_W),
  .PHYS_W(PHYS_W),
  .DATA_W(DATA_W)
) u_vam_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .legacy_mode(legacy_mode),
  .cmd_load   (cmd_load),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_wdata  (acc_wdata),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_swap   (mem_swap),
  .mem_wdata  (mem_wdata)
);

// File: tb/vram_addr_mapper_test.sv
`timescale 1ns/1ps
module vram_addr_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        legacy_mode = 1'b0;
  logic        xmem_en = 1'b0;
  logic        cmd_load = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic        inc_we = 1'b0;
  logic [7:0]  inc_val = '0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [15:0] acc_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_swap;
  logic [15:0] mem_wdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic [13:0] m_cnt = '0;
  logic [1:0]  m_page = '0;
  logic [7:0]  m_step = '0;
  bit          p_valid = 0;
  logic [15:0] p_addr;
  logic        p_swap;
  logic [15:0] p_data;
  string       p_tag;
  string       force_tag = "";

  always #10 clk = ~clk;

  vram_addr_mapper uut (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .xmem_en(xmem_en),
    .cmd_load(cmd_load), .cmd_addr(cmd_addr), .inc_we(inc_we), .inc_val(inc_val),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_wdata(acc_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_swap(mem_swap), .mem_wdata(mem_wdata)
  );

  function automatic logic [15:0] exp_phys(input logic [13:0] c, input logic [1:0] pg,
                                            input logic lg, input logic xe);
    logic [15:0] p;
    p = '0;
    if (lg) begin
      p[1] = c[9];
      for (int i = 2; i <= 9; i++) p[i] = c[i-1];
      p[13:10] = c[13:10];
    end else begin
      p = {(xe ? pg : 2'b00), c};
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus; called at a falling edge.
  task automatic tick(input bit av, input logic [15:0] wd, input bit mr, input bit cl,
                      input logic [15:0] ca, input bit iw, input logic [7:0] iv,
                      input bit lg, input bit xe);
    bit exp_rdy;
    acc_valid = av; acc_wdata = wd; mem_ready = mr; cmd_load = cl; cmd_addr = ca;
    inc_we = iw; inc_val = iv; legacy_mode = lg; xmem_en = xe;
    #1;
    exp_rdy = (!p_valid || mr) && !cl;
    check(mem_valid === p_valid, "R10", "mem_valid", {31'b0, mem_valid}, {31'b0, p_valid});
    check(acc_ready === exp_rdy, cl ? "R9" : "R10", "acc_ready",
          {31'b0, acc_ready}, {31'b0, exp_rdy});
    if (p_valid && mr) begin
      check(mem_addr === p_addr, p_tag, "mem_addr", {16'b0, mem_addr}, {16'b0, p_addr});
      check(mem_swap === p_swap && mem_wdata === p_data, p_tag, "swap/data",
            {15'b0, mem_swap, mem_wdata}, {15'b0, p_swap, p_data});
      p_valid = 0;
    end
    if (av && exp_rdy) begin
      p_valid = 1;
      p_addr  = exp_phys(m_cnt, m_page, lg, xe);
      p_swap  = lg && m_cnt[0];
      p_data  = p_swap ? {wd[7:0], wd[15:8]} : wd;
      p_tag   = (force_tag != "") ? force_tag : (lg ? "R3" : "R2");
      m_cnt   = lg ? m_cnt + {5'b0, m_step, 1'b0} : m_cnt + {6'b0, m_step};
    end
    if (cl) begin
      m_cnt  = ca[13:0];
      m_page = ca[15:14];
    end
    if (iw && !lg) m_step = iv; // R8: dropped in legacy mode
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input bit lg, input bit xe);
    tick(0, 16'h0, 1, 0, 16'h0, 0, 8'h0, lg, xe);
  endtask

  task automatic load(input logic [15:0] a, input bit lg, input bit xe);
    tick(0, 16'h0, 1, 1, a, 0, 8'h0, lg, xe);
  endtask

  task automatic set_step(input logic [7:0] v, input bit lg);
    tick(0, 16'h0, 1, 0, 16'h0, 1, v, lg, 0);
  endtask

  task automatic access(input logic [15:0] wd, input bit lg, input bit xe);
    tick(1, wd, 1, 0, 16'h0, 0, 8'h0, lg, xe);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(mem_valid === 1'b0, "R1", "mem_valid after reset", {31'b0, mem_valid}, 32'h0);
    check(acc_ready === 1'b1, "R1", "acc_ready after reset", {31'b0, acc_ready}, 32'h1);
    @(negedge clk);
    force_tag = "R1";
    access(16'hA55A, 0, 1);
    idle(0, 1);
    // R6 native wrap with page
    force_tag = "R6";
    set_step(8'd2, 0);
    load(16'hFFFE, 0, 1);
    access(16'h1111, 0, 1);
    access(16'h2222, 0, 1);
    access(16'h3333, 0, 0);
    idle(0, 0);
    // R3 permutation: bit 9 to bit 1, bit 1 to bit 2
    force_tag = "R3";
    set_step(8'd1, 0);
    load(16'h0200, 1, 0);
    access(16'h4444, 1, 0);
    load(16'h0102, 1, 0);
    access(16'h4545, 1, 0);
    load(16'h3C00, 1, 0);
    access(16'h4646, 1, 0);
    idle(1, 0);
    // R5 swap on bit 0
    force_tag = "R5";
    load(16'h0001, 1, 0);
    access(16'h1234, 1, 0);
    access(16'h5678, 1, 0);
    idle(1, 0);
    // R4 top bits zero in legacy even with page and expansion
    force_tag = "R4";
    load(16'hC002, 1, 1);
    access(16'h9999, 1, 1);
    idle(1, 1);
    // R7 legacy wrap 0x3FFE -> 0
    force_tag = "R7";
    load(16'h3FFE, 1, 0);
    access(16'h0F0F, 1, 0);
    access(16'hF0F0, 1, 0);
    idle(1, 0);
    // R8 step write dropped in legacy
    force_tag = "R8";
    set_step(8'd5, 1);
    load(16'h0000, 1, 0);
    access(16'h0101, 1, 0);
    access(16'h0202, 1, 0);
    access(16'h0303, 0, 0);
    idle(0, 0);
    // R10 stall with pending beat
    force_tag = "R10";
    access(16'h7777, 0, 0);
    tick(1, 16'h8888, 0, 0, 16'h0, 0, 8'h0, 0, 0);
    tick(1, 16'h8888, 0, 0, 16'h0, 0, 8'h0, 0, 0);
    tick(1, 16'h8888, 1, 0, 16'h0, 0, 8'h0, 0, 0);
    idle(0, 0);
    // random phase
    force_tag = "";
    void'($urandom(32'd1234));
    begin
      bit lg = 0;
      bit xe = 0;
      for (int n = 0; n < 600; n++) begin
        int r;
        r = $urandom_range(0, 99);
        if (r < 5) lg = ~lg;
        if (r >= 5 && r < 10) xe = ~xe;
        tick($urandom_range(0, 3) != 0, 16'($urandom), $urandom_range(0, 3) != 0,
             $urandom_range(0, 9) == 0,
             ($urandom_range(0, 1) == 1) ? {2'($urandom), 14'h3FF0 | 14'($urandom_range(0, 15))}
                                         : 16'($urandom),
             $urandom_range(0, 9) == 0, 8'($urandom_range(0, 7)), lg, xe);
      end
    end
    idle(0, 0);
    idle(0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule